// File: doc/BRIEF.md
# Timer Compare Event Unit

This block watches a free-running 64-bit time value and compares it against sixteen programmable 64-bit compare values. When the time value equals an enabled compare value, the block latches a per-compare status bit, raises a sticky level output and a single-cycle pulse output for that compare, and raises a shared event line that can feed an interrupt controller. The timer that produces the time value is outside this block.

Compare 0 has a second role. When configured to do so, a hit on compare 0 raises a counter-reset request toward the timer. Compare values can be staged. With staging on, software writes land in a holding copy, and all holding copies move into the active compares together when compare 0 resets the counter. Software gets new compare values for the next timer period without changing the active values partway through a period.

All state is reached through a 32-bit word-addressed register port. Compare j occupies two words: the low half is at word address 4+2j and the high half is at word address 5+2j.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset, every status bit, level output, pulse output, the event output and the reset request are 0. The configuration word (address 0), the enable word (address 1) and all compare values are 0.
- R2: If the time input equals the active value of compare j and enable bit j (address 1, bit j) is 1, status bit j and level output j are 1 from the next clock edge on. They stay 1 until cleared.
- R3: Pulse output j is 1 only in the cycle that follows a cycle in which compare j hit, and is 0 otherwise.
- R4: The event output is 1 in the cycle after any enabled compare hits, and is 0 otherwise.
- R5: Writing the status word (address 2) clears each status bit, and its level output, whose data bit is 1. Data bits that are 0 leave their status bits unchanged. Reading address 2 returns the status bits.
- R6: If a clear of status bit j and a hit on compare j happen in the same cycle, status bit j stays 1.
- R7: A compare whose enable bit is 0 never sets its status bit, level output or pulse output, and never contributes to the event output.
- R8: With configuration bit 0 set, a hit on compare 0 raises the counter-reset request for one cycle, in the cycle after the hit. With bit 0 clear, the request stays 0.
- R9: With configuration bit 17 clear, a write to a compare half takes effect in the active compare from the next cycle.
- R10: With configuration bit 17 set, compare writes go only to the holding copies. All holding copies load into the active compares at the clock edge that ends a compare-0 hit made while configuration bit 0 is set.
- R11: Compare j's low 32 bits are written at word address 4+2j and its high 32 bits at 5+2j. A hit needs all 64 bits to match. Reading address 0 returns bit 0 and bit 17 of the configuration. Reads of addresses with no readable register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeIn | input | 64 | Running timer value |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | AW | Word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| levelOut | output | 16 | Sticky per-compare hit levels (status bits) |
| pulseOut | output | 16 | Single-cycle per-compare hit pulses |
| cmpEvent | output | 1 | Any-compare event |
| cntRstReq | output | 1 | Counter reset request toward the timer |

## Verification
The bench targets the race between a status clear and a new hit in the same cycle. A design that gives the clear priority would drop that event and leave the level low. It clears one of two set status bits and checks that the other survives, which catches a clear that wipes the whole word. Disabled compares are driven with matching time values, and a design that ignored the enable would raise a pulse or set status. Staging is checked in three steps: a staged value must not hit before the compare-0 reset, the old value must still hit, and after the reset the staged value must hit. This catches designs that write through, never load, or load on the wrong event. A time value that differs from a compare only in its high half must not hit, which catches a truncated comparator or a swapped half address.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int REG_W         = 32;
  localparam int IDX_W         = 8;
  localparam int CFG_RST_BIT   = 0;
  localparam int CFG_SHD_BIT   = 17;
  localparam int ADDR_CFG      = 0;
  localparam int ADDR_EN       = 1;
  localparam int ADDR_STAT     = 2;
  localparam int ADDR_CMP_BASE = 4;

  // Strobes from control to the compare datapath
  typedef struct packed {
    logic             wrLo;
    logic             wrHi;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] data;
    logic             direct;      // write goes straight to the active copy
    logic             shadowLoad;  // move holding copies into active copies
  } cmpStrobe_t;
endpackage

// File: rtl/tcu_cmp_datapath.sv
module tcu_cmp_datapath
  import tcu_pkg::*;
#(
  parameter int NUM_CMP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cmpStrobe_t         stb,
  input  logic [2*REG_W-1:0] timeIn,
  output logic [NUM_CMP-1:0] matchRaw
);
  localparam int TW = 2 * REG_W;

  for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
    logic [TW-1:0] shdVal;
    logic [TW-1:0] actVal;
    logic          sel;

    assign sel = (stb.idx == IDX_W'(j));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shdVal <= '0;
        actVal <= '0;
      end else begin
        if (stb.shadowLoad) actVal <= shdVal;
        if (sel && stb.wrLo) begin
          shdVal[REG_W-1:0] <= stb.data;
          if (stb.direct) actVal[REG_W-1:0] <= stb.data;
        end
        if (sel && stb.wrHi) begin
          shdVal[TW-1:REG_W] <= stb.data;
          if (stb.direct) actVal[TW-1:REG_W] <= stb.data;
        end
      end
    end

    assign matchRaw[j] = (timeIn == actVal);
  end
endmodule

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int AW      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [AW-1:0]      regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [NUM_CMP-1:0] matchRaw,
  output cmpStrobe_t         stb,
  output logic [NUM_CMP-1:0] statusQ,
  output logic [NUM_CMP-1:0] pulseQ,
  output logic               eventQ,
  output logic               cntRstQ,
  output logic [NUM_CMP-1:0] cmpEn,
  output logic               rstEn,
  output logic               shadowEn
);
  localparam int CMP_END = ADDR_CMP_BASE + 2 * NUM_CMP;

  logic               inCmpRange;
  logic [AW-1:0]      cmpOff;
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] clrMask;
  logic               wrCfg, wrEn, wrStat;

  assign inCmpRange = (int'(regAddr) >= ADDR_CMP_BASE) && (int'(regAddr) < CMP_END);
  assign cmpOff     = regAddr - AW'(ADDR_CMP_BASE);
  assign wrCfg      = regWrEn && (regAddr == AW'(ADDR_CFG));
  assign wrEn       = regWrEn && (regAddr == AW'(ADDR_EN));
  assign wrStat     = regWrEn && (regAddr == AW'(ADDR_STAT));

  assign hit     = matchRaw & cmpEn;
  assign clrMask = wrStat ? regWrData[NUM_CMP-1:0] : '0;

  always_comb begin
    stb            = '0;
    stb.wrLo       = regWrEn && inCmpRange && !cmpOff[0];
    stb.wrHi       = regWrEn && inCmpRange && cmpOff[0];
    stb.idx        = IDX_W'(cmpOff >> 1);
    stb.data       = regWrData;
    stb.direct     = !shadowEn;
    stb.shadowLoad = hit[0] && rstEn && shadowEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstEn    <= 1'b0;
      shadowEn <= 1'b0;
      cmpEn    <= '0;
    end else begin
      if (wrCfg) begin
        rstEn    <= regWrData[CFG_RST_BIT];
        shadowEn <= regWrData[CFG_SHD_BIT];
      end
      if (wrEn) cmpEn <= regWrData[NUM_CMP-1:0];
    end
  end

  // A new hit takes precedence over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= '0;
      pulseQ  <= '0;
      eventQ  <= 1'b0;
      cntRstQ <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | hit;
      pulseQ  <= hit;
      eventQ  <= |hit;
      cntRstQ <= hit[0] && rstEn;
    end
  end

  always_comb begin
    regRdData = '0;
    case (int'(regAddr))
      ADDR_CFG: begin
        regRdData[CFG_RST_BIT] = rstEn;
        regRdData[CFG_SHD_BIT] = shadowEn;
      end
      ADDR_EN:   regRdData[NUM_CMP-1:0] = cmpEn;
      ADDR_STAT: regRdData[NUM_CMP-1:0] = statusQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tcu_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int AW      = $clog2(tcu_pkg::ADDR_CMP_BASE + 2 * NUM_CMP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*tcu_pkg::REG_W-1:0] timeIn,
  input  logic                      regWrEn,
  input  logic [AW-1:0]             regAddr,
  input  logic [tcu_pkg::REG_W-1:0] regWrData,
  output logic [tcu_pkg::REG_W-1:0] regRdData,
  output logic [NUM_CMP-1:0]        levelOut,
  output logic [NUM_CMP-1:0]        pulseOut,
  output logic                      cmpEvent,
  output logic                      cntRstReq
);
  cmpStrobe_t         stb;
  logic [NUM_CMP-1:0] matchRaw;
  logic [NUM_CMP-1:0] cmpEn;
  logic               rstEn;
  logic               shadowEn;

  tcu_ctrl #(.NUM_CMP(NUM_CMP), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .matchRaw(matchRaw),
    .stb(stb), .statusQ(levelOut), .pulseQ(pulseOut), .eventQ(cmpEvent),
    .cntRstQ(cntRstReq), .cmpEn(cmpEn), .rstEn(rstEn), .shadowEn(shadowEn)
  );

  tcu_cmp_datapath #(.NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .timeIn(timeIn), .matchRaw(matchRaw)
  );
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker
  import tcu_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int AW      = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               regWrEn,
  input logic [AW-1:0]      regAddr,
  input logic [NUM_CMP-1:0] levelOut,
  input logic [NUM_CMP-1:0] pulseOut,
  input logic               cmpEvent,
  input logic               cntRstReq,
  input logic [NUM_CMP-1:0] cmpEn,
  input logic               rstEn
);
  // R3: a pulse is always accompanied by its level
  a_r3_pulse_has_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseOut & ~levelOut) == '0);

  // R4: the shared event tracks the set of pulses
  a_r4_event_any_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmpEvent == (|pulseOut));

  // R2: a level only drops after a status write
  a_r2_level_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && regAddr == AW'(ADDR_STAT)) |=> ((levelOut & $past(levelOut)) == $past(levelOut)));

  // R7: no pulse from a compare that was disabled
  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseOut & ~$past(cmpEn)) == '0);

  // R8: reset request only from a compare-0 hit with reset enabled
  a_r8_rst_from_cmp0: assert property (@(posedge clk) disable iff (!rst_n)
    cntRstReq |-> (pulseOut[0] && $past(rstEn)));
endmodule

bind tmr_cmp_unit tcu_checker #(.NUM_CMP(NUM_CMP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .levelOut(levelOut), .pulseOut(pulseOut), .cmpEvent(cmpEvent),
  .cntRstReq(cntRstReq), .cmpEn(cmpEn), .rstEn(rstEn)
);

// File: tb/tmr_cmp_unit_test.sv
`timescale 1ns/1ps
module tmr_cmp_unit_test;
  localparam int NC = 16;
  localparam int AW = 6;
  localparam logic [63:0] IDLE = 64'hFFFF_FFFF_FFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] timeIn = IDLE;
  logic        regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NC-1:0] levelOut, pulseOut;
  logic        cmpEvent, cntRstReq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_cmp_unit uut (
    .clk(clk), .rst_n(rst_n), .timeIn(timeIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .levelOut(levelOut), .pulseOut(pulseOut), .cmpEvent(cmpEvent),
    .cntRstReq(cntRstReq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = AW'(a);
    #1 d = regRdData;
  endtask

  task automatic wrCmp(int j, logic [63:0] v);
    wrReg(4 + 2 * j, v[31:0]);
    wrReg(5 + 2 * j, v[63:32]);
  endtask

  // drive one cycle of time, return with outputs of the following cycle visible
  task automatic applyTime(logic [63:0] v);
    @(negedge clk);
    timeIn = v;
    @(negedge clk);
    timeIn = IDLE;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 level", 64'(levelOut), 0);
    check("R1 pulse", 64'(pulseOut), 0);
    check("R1 event", 64'(cmpEvent), 0);
    check("R1 rstreq", 64'(cntRstReq), 0);
    rdReg(0, d); check("R1 cfg", 64'(d), 0);
    rdReg(1, d); check("R1 enable", 64'(d), 0);
    rdReg(2, d); check("R1 status", 64'(d), 0);
  endtask

  task automatic testBasicHit();
    logic [31:0] d;
    wrReg(1, 32'h0000_8009);
    wrCmp(3, 64'h0000_0012_3456_789A);
    applyTime(64'h0000_0012_3456_789A);
    check("R3 pulse on hit", 64'(pulseOut), 64'h8);
    check("R2 level on hit", 64'(levelOut), 64'h8);
    check("R4 event on hit", 64'(cmpEvent), 1);
    check("R9 direct write active", 64'(pulseOut[3]), 1);
    @(negedge clk);
    check("R3 pulse single cycle", 64'(pulseOut), 0);
    check("R2 level held", 64'(levelOut), 64'h8);
    check("R4 event drops", 64'(cmpEvent), 0);
    rdReg(2, d); check("R5 status readback", 64'(d), 64'h8);
  endtask

  task automatic testClear();
    wrCmp(0, 64'h0000_0000_0000_0777);
    applyTime(64'h0000_0000_0000_0777);
    check("R2 two levels", 64'(levelOut), 64'h9);
    check("R8 no rst when disabled", 64'(cntRstReq), 0);
    wrReg(2, 32'h0000_0008);
    check("R5 partial clear", 64'(levelOut), 64'h1);
    wrReg(2, 32'h0000_0001);
    check("R5 full clear", 64'(levelOut), 0);
  endtask

  task automatic testSetWins();
    applyTime(64'h0000_0012_3456_789A);
    @(negedge clk);
    timeIn = 64'h0000_0012_3456_789A;
    regWrEn = 1'b1; regAddr = AW'(2); regWrData = 32'h0000_0008;
    @(negedge clk);
    regWrEn = 1'b0; timeIn = IDLE;
    check("R6 set beats clear", 64'(levelOut[3]), 1);
    wrReg(2, 32'hFFFF);
    check("R6 later clear", 64'(levelOut), 0);
  endtask

  task automatic testDisabled();
    wrCmp(5, 64'h0ABC_0000_0000_5555);
    applyTime(64'h0ABC_0000_0000_5555);
    check("R7 disabled no pulse", 64'(pulseOut), 0);
    check("R7 disabled no level", 64'(levelOut), 0);
    check("R7 disabled no event", 64'(cmpEvent), 0);
  endtask

  task automatic testMultiAndHalves();
    wrReg(1, 32'h0000_8029);
    wrCmp(15, 64'h0ABC_0000_0000_5555);
    applyTime(64'h0ABC_0000_0000_5554);
    check("R11 low half differs", 64'(pulseOut), 0);
    applyTime(64'h0ABD_0000_0000_5555);
    check("R11 high half differs", 64'(pulseOut), 0);
    applyTime(64'h0ABC_0000_0000_5555);
    check("R2 two compares same value", 64'(pulseOut), 64'h8020);
    check("R4 event multi", 64'(cmpEvent), 1);
    wrReg(2, 32'hFFFF);
    check("R5 cleared multi", 64'(levelOut), 0);
  endtask

  task automatic testCntReset();
    logic [31:0] d;
    wrReg(0, 32'h0000_0001);
    applyTime(64'h0000_0000_0000_0777);
    check("R8 rst request", 64'(cntRstReq), 1);
    @(negedge clk);
    check("R8 rst one cycle", 64'(cntRstReq), 0);
    wrReg(2, 32'hFFFF);
    rdReg(3, d); check("R11 unmapped read", 64'(d), 0);
  endtask

  task automatic testShadow();
    logic [31:0] d;
    wrReg(1, 32'h0000_0089);
    wrCmp(7, 64'h0000_0001_0000_00B0);
    wrReg(0, 32'h0002_0001);
    rdReg(0, d); check("R11 cfg readback", 64'(d), 64'h2_0001);
    wrCmp(7, 64'h0000_0001_0000_00A0);
    applyTime(64'h0000_0001_0000_00A0);
    check("R10 staged not active", 64'(pulseOut[7]), 0);
    applyTime(64'h0000_0001_0000_00B0);
    check("R10 old value active", 64'(pulseOut[7]), 1);
    wrReg(2, 32'hFFFF);
    applyTime(64'h0000_0000_0000_0777);
    check("R8 rst in shadow", 64'(cntRstReq), 1);
    wrReg(2, 32'hFFFF);
    applyTime(64'h0000_0001_0000_00A0);
    check("R10 staged loaded", 64'(pulseOut[7]), 1);
    applyTime(64'h0000_0001_0000_00B0);
    check("R10 old value gone", 64'(pulseOut[7]), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testBasicHit();
    testClear();
    testSetWins();
    testDisabled();
    testMultiAndHalves();
    testCntReset();
    testShadow();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule